// File: doc/BRIEF.md
# Panel Packet Receiver with Link Watchdog

This block sits on the main-unit end of a serial link from a control panel. It holds its own asynchronous receiver for 8N1 characters. From those characters it builds fixed-length panel packets. Each character carries a 7-bit payload in bits 6..0. Bit 7 is set only on the first character of a packet, so the receiver can find packet boundaries after any disturbance on the line. It needs no timing gaps and no count from power-up to do this.

When the last octet of a packet arrives, the block publishes the packet and pulses a strobe for one clock. The first two octets are signed encoder counts, with clockwise positive, and they come out sign-extended to 8 bits. The remaining octets are raw 7-bit control readings and come out on one flat vector. A loss-of-link watchdog counts clock cycles since the last complete packet. When the count reaches its limit, the block raises a power-off request. That request stays set until reset. The surrounding logic switches the power and acts on the decoded values.

Top module: `panel_rx`

## Requirements
- R1: The serial input idles high. A character is a falling edge followed by a start bit that is still low at mid-bit, then 8 data bits LSB first, then one stop bit. Each bit lasts CLK_PER_BIT clocks.
- R2: A character with bit 7 = 1 begins a packet, and its bits 6..0 become octet 0.
- R3: Characters with bit 7 = 0 fill octets 1 to PKT_LEN-1 in arrival order. Octet k (k >= 2) appears on ctrl[(k-2)*7 +: 7].
- R4: enc_left and enc_right are octets 0 and 1 read as 7-bit two's complement and sign-extended to 8 bits.
- R5: Storing octet PKT_LEN-1 publishes the packet and raises pkt_valid for exactly one cycle. At all other times the outputs hold their values.
- R6: A character with bit 7 = 1 that arrives before a packet is complete discards the partial packet and starts a new one.
- R7: A character with bit 7 = 0 that arrives while no packet is in progress is dropped.
- R8: A low stop bit drops the character and aborts any packet in progress. Reception then resumes at the next character with bit 7 = 1.
- R9: power_off_req rises once WDOG_CYCLES clocks have passed since reset, or since the last pkt_valid, with no new complete packet.
- R10: Once set, power_off_req stays high until reset, even when packets arrive later.
- R11: During and right after reset, enc_left, enc_right, ctrl, pkt_valid and power_off_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial line from the panel (asynchronous, idles high) |
| enc_left | output | 8 | Left encoder delta, sign-extended |
| enc_right | output | 8 | Right encoder delta, sign-extended |
| ctrl | output | (PKT_LEN-2)*7 | Control octets 2 to PKT_LEN-1, 7 bits each |
| pkt_valid | output | 1 | One-cycle strobe when a new packet is published |
| power_off_req | output | 1 | Sticky shutdown request from the watchdog |

## Verification
The bench builds the block with CLK_PER_BIT = 8 and WDOG_CYCLES = 4000, and keeps the default PKT_LEN of 13. A packet then takes about a thousand clocks, so aborted and restarted packets still fit inside one watchdog window. A deliberate silence after them makes the watchdog expire within a few thousand cycles, and its exact cycle of expiry is checked. The sticky request is checked by sending a valid packet after the timeout, and a second reset then shows that the request clears.

// File: rtl/panel_rx.sv
module panel_rx #(
  parameter int CLK_PER_BIT = 2604,
  parameter int PKT_LEN     = 13,
  parameter int WDOG_CYCLES = 25_000_000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_in,
  output logic signed [7:0]          enc_left,
  output logic signed [7:0]          enc_right,
  output logic [(PKT_LEN-2)*7-1:0]   ctrl,
  output logic                       pkt_valid,
  output logic                       power_off_req
);
  localparam int CW   = $clog2(CLK_PER_BIT);
  localparam int HALF = CLK_PER_BIT / 2;
  localparam int IW   = $clog2(PKT_LEN);
  localparam int PW   = PKT_LEN * 7;
  localparam int WW   = $clog2(WDOG_CYCLES);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_t;

  logic [1:0]    sync_q;
  logic          prev_q;
  rx_st_t        st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          ok_q, err_q;

  logic          rx_s;
  assign rx_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_in};
      prev_q <= rx_s;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE:
          if (prev_q && !rx_s) begin
            st_q  <= S_START;
            cnt_q <= '0;
          end
        S_START:
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? S_IDLE : S_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        S_DATA:
          if (cnt_q == CW'(CLK_PER_BIT - 1)) begin
            cnt_q <= '0;
            sh_q  <= {rx_s, sh_q[7:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) st_q <= S_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        S_STOP:
          if (cnt_q == CW'(CLK_PER_BIT - 1)) begin
            cnt_q <= '0;
            ok_q  <= rx_s;
            err_q <= !rx_s;
            st_q  <= S_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] asm_q, pub_q, merged;
  logic          done;

  always_comb begin
    merged = asm_q;
    merged[int'(idx_q)*7 +: 7] = sh_q[6:0];
  end

  assign done = ok_q && !sh_q[7] && busy_q && idx_q == IW'(PKT_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      asm_q     <= '0;
      pub_q     <= '0;
      pkt_valid <= 1'b0;
    end else begin
      pkt_valid <= done;
      if (err_q) busy_q <= 1'b0;
      else if (ok_q) begin
        if (sh_q[7]) begin
          asm_q[6:0] <= sh_q[6:0];
          idx_q      <= IW'(1);
          busy_q     <= 1'b1;
        end else if (busy_q) begin
          asm_q <= merged;
          if (done) begin
            pub_q  <= merged;
            busy_q <= 1'b0;
          end else idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign enc_left  = {pub_q[6],  pub_q[6:0]};
  assign enc_right = {pub_q[13], pub_q[13:7]};
  assign ctrl      = pub_q[PW-1:14];

  logic [WW-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q          <= '0;
      power_off_req <= 1'b0;
    end else if (done) begin
      wd_q <= '0;
    end else if (wd_q == WW'(WDOG_CYCLES - 1)) begin
      power_off_req <= 1'b1;
    end else begin
      wd_q <= wd_q + 1'b1;
    end
  end
endmodule

// File: rtl/panel_rx_chk.sv
module panel_rx_chk (
  input logic              clk,
  input logic              rst,
  input logic signed [7:0] enc_left,
  input logic signed [7:0] enc_right,
  input logic              pkt_valid,
  input logic              power_off_req
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> !pkt_valid);                                        // R5
  AST_LEFT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |-> $stable(enc_left));                                // R5
  AST_RIGHT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |-> $stable(enc_right));                               // R5
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    power_off_req |=> power_off_req);                                 // R10
  AST_PACKET_FEEDS_DOG: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !power_off_req) |=> !power_off_req);                // R9
endmodule

bind panel_rx panel_rx_chk u_chk (.*);

// File: tb/panel_rx_test.sv
module panel_rx_test;
  localparam int CPB  = 8;
  localparam int PLEN = 13;
  localparam int WDOG = 4000;
  localparam int PW   = PLEN * 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic signed [7:0] enc_left, enc_right;
  logic [(PLEN-2)*7-1:0] ctrl;
  logic pkt_valid, power_off_req;

  always #10 clk = ~clk;

  panel_rx #(.CLK_PER_BIT(CPB), .PKT_LEN(PLEN), .WDOG_CYCLES(WDOG)) uut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .enc_left(enc_left),
    .enc_right(enc_right), .ctrl(ctrl), .pkt_valid(pkt_valid),
    .power_off_req(power_off_req));

  int checks = 0, fails = 0;
  logic [PW-1:0] expq[$];
  int  quiet = 0;
  bit  exp_off = 1'b0;
  bit  rst_seen = 1'b1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_seen) begin
      quiet = 0;
      exp_off = 1'b0;
    end else begin
      if (pkt_valid) begin
        quiet = 0;
        if (expq.size() == 0) chk(0, "R5/R6/R7/R8 unexpected pkt_valid", 1, 0);
        else begin
          logic [PW-1:0] e;
          e = expq.pop_front();
          chk(enc_left  == {e[6], e[6:0]},   "R4 enc_left",  enc_left,  $signed({e[6], e[6:0]}));
          chk(enc_right == {e[13], e[13:7]}, "R4 enc_right", enc_right, $signed({e[13], e[13:7]}));
          for (int k = 2; k < PLEN; k++)
            chk(ctrl[(k-2)*7 +: 7] == e[k*7 +: 7], "R3 ctrl octet",
                ctrl[(k-2)*7 +: 7], e[k*7 +: 7]);
        end
      end else quiet++;
      if (quiet >= WDOG) exp_off = 1'b1;
      chk(power_off_req == exp_off, "R9/R10 power_off_req", power_off_req, exp_off);
    end
    rst_seen = rst;
  end

  task automatic send_byte(logic [7:0] b, bit good_stop = 1'b1);
    rx_in = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_in = good_stop;
    repeat (CPB) @(negedge clk);
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_pkt(logic [PW-1:0] p);
    expq.push_back(p);
    send_byte({1'b1, p[6:0]});
    for (int k = 1; k < PLEN; k++) send_byte({1'b0, p[k*7 +: 7]});
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [PW-1:0] mk(int l, int r, int seed);
    logic [PW-1:0] p;
    p[6:0]  = 7'(l);
    p[13:7] = 7'(r);
    for (int k = 2; k < PLEN; k++) p[k*7 +: 7] = 7'(seed * 13 + k * 29);
    return p;
  endfunction

  task automatic do_reset();
    @(posedge clk); #2 rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_reset_state(string tag);
    chk(enc_left == 0,       {tag, " R11 enc_left"},  enc_left, 0);
    chk(enc_right == 0,      {tag, " R11 enc_right"}, enc_right, 0);
    chk(ctrl == '0,          {tag, " R11 ctrl"},      ctrl == '0 ? 0 : 1, 0);
    chk(pkt_valid == 0,      {tag, " R11 pkt_valid"}, pkt_valid, 0);
    chk(power_off_req == 0,  {tag, " R11 power_off"}, power_off_req, 0);
  endtask

  initial begin
    fork
      begin
        do_reset();
        check_reset_state("initial");
        send_pkt(mk(3, 5, 1));                  // R1 R2 R3 R4 R5 positive
        send_pkt(mk(-1, -64, 2));               // R4 negative extremes
        send_pkt(mk(63, -7, 3));                // R4 max positive
        send_byte(8'h85); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        send_pkt(mk(-20, 9, 4));                // R6 marker restarts partial
        send_byte(8'h12); send_byte(8'h7f); send_byte(8'h00);
        send_pkt(mk(1, -2, 5));                 // R7 stray continuations
        send_byte(8'h8a); send_byte(8'h01); send_byte(8'h02);
        send_byte(8'h03, 1'b0);                 // R8 framing error
        for (int k = 0; k < PLEN; k++) send_byte(8'h05);
        send_pkt(mk(10, 11, 6));                // R8 resumes at marker
        send_byte(8'h81); send_byte(8'h01, 1'b0);
        send_byte(8'h81, 1'b0);                 // R8 bad marker ignored
        send_pkt(mk(-33, 44, 7));
        repeat (WDOG + 200) @(negedge clk);     // R9 timeout
        chk(power_off_req == 1, "R9 request after silence", power_off_req, 1);
        send_pkt(mk(2, 2, 8));                  // R10 stays set
        chk(power_off_req == 1, "R10 sticky after packet", power_off_req, 1);
        do_reset();
        check_reset_state("second");            // R10 cleared by reset, R11
        repeat (50) @(negedge clk);
        chk(expq.size() == 0, "R5 all expected packets seen", expq.size(), 0);
      end
      begin
        repeat (200_000) @(posedge clk);
        chk(0, "watchdog run timeout", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule